// File: doc/BRIEF.md
# Fault-Reactive Contactor Reconfiguration Controller

This block keeps the four buses of a small two-source, two-rectifier power distribution network energised by choosing, every control cycle, which of six contactors are closed. It watches four health flags (left and right generator, left and right rectifier unit). When one source on a side fails, it opens that source's contactor and then closes the side's tie contactor, so that the surviving source feeds both buses of that side. When both sources on a side fail, the operating assumptions are broken. The controller then enters a terminal stall and freezes its contactor commands until a synchronous reset.

Each control cycle has a fixed sequence. The four health flags are latched one at a time, the reconfiguration automaton is evaluated, and then new contactor commands are written. The write is skipped when nothing changed. Writes are break-before-make: all openings are issued first, and closings follow only after a programmable relay-settling delay. As a result, a side never has both source contactors and its tie contactor closed at once. A parameter selects one of two forms. The centralized form treats any broken assumption as a stall of the whole controller. The split form runs independent AC and DC automata, so a stall on one side leaves the other side reacting.

Top module: `pdn_reconfig_ctrl`

## Requirements
- R1: After a synchronous reset the outputs are as follows. `cont_cmd` is 6'b011011, with bit positions [0] AC left source, [1] AC right source, [2] AC tie, [3] DC left source, [4] DC right source, [5] DC tie, and 1 meaning closed. `stall` is 2'b00 and `bus_pwr` is 4'b1111.
- R2: On every clock, `cont_cmd[2:0]` is never 3'b111 and `cont_cmd[5:3]` is never 3'b111.
- R3: On the AC side, a settled `cont_cmd[2:0]` depends on the generator flags. Both generators healthy gives 3'b011. Right generator unhealthy gives 3'b101. Left generator unhealthy gives 3'b110.
- R4: On the DC side, `cont_cmd[5:3]` follows the same mapping using the left and right rectifier flags.
- R5: A change of contactor commands never opens and closes contactors in the same cycle. When both are needed, the closings appear exactly RELAY_DLY clock cycles after the openings.
- R6: While the health flags are unchanged, `cont_cmd` stays constant, because the write step is skipped.
- R7: If both generators are unhealthy at an evaluation, `stall[0]` rises. It stays set until reset, and `cont_cmd[2:0]` holds its value even after the generators recover.
- R8: If both rectifiers are unhealthy at an evaluation, `stall[1]` rises. It stays set until reset, and `cont_cmd[5:3]` holds its value.
- R9: The response to a broken assumption depends on the mode. With SPLIT_MODE=1, a stall on one side leaves the other side's automaton reacting normally. With SPLIT_MODE=0, a broken assumption on either side sets both `stall` bits and freezes all six commands.
- R10: `bus_pwr` reports each bus as powered when a closed path exists from a source sampled healthy to that bus. The bit positions are [0] AC left, [1] AC right, [2] DC left and [3] DC right.
- R11: After any single fault or recovery that keeps the assumptions true, all four `bus_pwr` bits are 1 again within 3*(RELAY_DLY+10) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_l_ok | input | 1 | Left generator healthy |
| gen_r_ok | input | 1 | Right generator healthy |
| ru_l_ok | input | 1 | Left rectifier unit healthy |
| ru_r_ok | input | 1 | Right rectifier unit healthy |
| cont_cmd | output | 6 | Contactor close commands (map in R1) |
| bus_pwr | output | 4 | Bus powered status (map in R10) |
| stall | output | 2 | [0] AC side stalled, [1] DC side stalled |

## Verification
The hardest situation to reach is a stall that lands while the contactors sit in a reconfigured, non-reset state, followed by a recovery of the failed sources. Only that sequence shows that the frozen commands differ from what a live automaton would choose. The stimulus first fails one generator and lets the tie close. It then fails the second generator, then restores both, and checks that the held pattern survives. Split and centralized instances receive the same flags side by side, so the divergence between the two modes is observed directly.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  localparam int NUM_HEALTH = 4;
  localparam int NUM_CONT   = 6;
  localparam int NUM_BUS    = 4;
  localparam int NUM_SIDE   = 2;
  localparam int SIDE_W     = NUM_CONT / NUM_SIDE;

  // per side triple: [0] left source, [1] right source, [2] tie
  localparam logic [SIDE_W-1:0] TRI_BOTH   = 3'b011;
  localparam logic [SIDE_W-1:0] TRI_LEFT   = 3'b101;
  localparam logic [SIDE_W-1:0] TRI_RIGHT  = 3'b110;

  typedef enum logic [1:0] {
    SEQ_READ   = 2'd0,
    SEQ_EVAL   = 2'd1,
    SEQ_WSTART = 2'd2,
    SEQ_WWAIT  = 2'd3
  } seq_t;
endpackage

// File: rtl/pdn_health_sampler.sv
module pdn_health_sampler
  import pdn_pkg::*;
#(
  parameter int N = NUM_HEALTH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [$clog2(N)-1:0] rd_idx,
  input  logic [N-1:0]         health_in,
  output logic [N-1:0]         health_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      health_q <= '1;
    end else if (rd_en) begin
      health_q[rd_idx] <= health_in[rd_idx];
    end
  end
endmodule

// File: rtl/pdn_side_fsm.sv
module pdn_side_fsm
  import pdn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              eval,
  input  logic              ok_l,
  input  logic              ok_r,
  input  logic              peer_halt,
  output logic              fault,
  output logic              stalled,
  output logic [SIDE_W-1:0] tgt
);
  assign fault = !ok_l && !ok_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled <= 1'b0;
      tgt     <= TRI_BOTH;
    end else if (eval && !stalled) begin
      if (fault || peer_halt) begin
        stalled <= 1'b1;
      end else if (ok_l && ok_r) begin
        tgt <= TRI_BOTH;
      end else if (ok_l) begin
        tgt <= TRI_LEFT;
      end else begin
        tgt <= TRI_RIGHT;
      end
    end
  end

  // R7 / R8: stall is terminal until reset
  assert_stall_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(stalled) |-> stalled);
endmodule

// File: rtl/pdn_bbm_writer.sv
module pdn_bbm_writer
  import pdn_pkg::*;
#(
  parameter int                RELAY_DLY = 20000,
  parameter logic [NUM_CONT-1:0] RST_CMD = {TRI_BOTH, TRI_BOTH}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NUM_CONT-1:0] tgt,
  output logic [NUM_CONT-1:0] cmd,
  output logic                busy
);
  localparam int CW = (RELAY_DLY > 1) ? $clog2(RELAY_DLY) : 1;

  logic [CW-1:0]       cnt;
  logic [NUM_CONT-1:0] pend;
  logic [NUM_CONT-1:0] to_close;

  assign to_close = tgt & ~cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= RST_CMD;
      busy <= 1'b0;
      cnt  <= '0;
      pend <= RST_CMD;
    end else if (busy) begin
      if (cnt == '0) begin
        cmd  <= pend;
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start && (tgt != cmd)) begin
      cmd <= cmd & tgt;
      if (to_close != '0) begin
        busy <= 1'b1;
        cnt  <= CW'(RELAY_DLY - 1);
        pend <= tgt;
      end
    end
  end

  assert_no_parallel_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd[2:0] != 3'b111) && (cmd[5:3] != 3'b111));

  assert_break_first_R5: assert property (@(posedge clk) disable iff (rst)
    ((cmd & ~$past(cmd)) != '0) |-> (($past(cmd) & ~cmd) == '0));
endmodule

// File: rtl/pdn_bus_monitor.sv
module pdn_bus_monitor
  import pdn_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_HEALTH-1:0] health,
  input  logic [NUM_CONT-1:0]   cmd,
  output logic [NUM_BUS-1:0]    bus_pwr
);
  logic [NUM_BUS-1:0] path;

  for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
    logic hl, hr;
    logic [SIDE_W-1:0] c;
    assign hl = health[2*s];
    assign hr = health[2*s+1];
    assign c  = cmd[SIDE_W*s +: SIDE_W];
    assign path[2*s]   = (c[0] && hl) || (c[2] && c[1] && hr);
    assign path[2*s+1] = (c[1] && hr) || (c[2] && c[0] && hl);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_pwr <= '1;
    else     bus_pwr <= path;
  end
endmodule

// File: rtl/pdn_reconfig_ctrl.sv
module pdn_reconfig_ctrl
  import pdn_pkg::*;
#(
  parameter bit SPLIT_MODE = 1'b1,
  parameter int RELAY_DLY  = 20000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gen_l_ok,
  input  logic                gen_r_ok,
  input  logic                ru_l_ok,
  input  logic                ru_r_ok,
  output logic [NUM_CONT-1:0] cont_cmd,
  output logic [NUM_BUS-1:0]  bus_pwr,
  output logic [NUM_SIDE-1:0] stall
);
  localparam int IW = $clog2(NUM_HEALTH);

  seq_t                  seq_q;
  logic [IW-1:0]         idx_q;
  logic [NUM_HEALTH-1:0] health_in, health_q;
  logic [NUM_SIDE-1:0]   fault_w, stalled_w;
  logic [NUM_CONT-1:0]   tgt_w;
  logic                  busy_w;

  assign health_in = {ru_r_ok, ru_l_ok, gen_r_ok, gen_l_ok};

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SEQ_READ;
      idx_q <= '0;
    end else begin
      case (seq_q)
        SEQ_READ: begin
          if (idx_q == IW'(NUM_HEALTH - 1)) begin
            idx_q <= '0;
            seq_q <= SEQ_EVAL;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SEQ_EVAL:   seq_q <= SEQ_WSTART;
        SEQ_WSTART: seq_q <= SEQ_WWAIT;
        default:    if (!busy_w) seq_q <= SEQ_READ;
      endcase
    end
  end

  pdn_health_sampler #(.N(NUM_HEALTH)) u_samp (
    .clk(clk), .rst(rst),
    .rd_en(seq_q == SEQ_READ), .rd_idx(idx_q),
    .health_in(health_in), .health_q(health_q)
  );

  for (genvar s = 0; s < NUM_SIDE; s++) begin : g_fsm
    logic peer_halt;
    if (SPLIT_MODE) begin : g_split
      assign peer_halt = 1'b0;
    end else begin : g_central
      assign peer_halt = fault_w[1-s] || stalled_w[1-s];
    end
    pdn_side_fsm u_fsm (
      .clk(clk), .rst(rst),
      .eval(seq_q == SEQ_EVAL),
      .ok_l(health_q[2*s]), .ok_r(health_q[2*s+1]),
      .peer_halt(peer_halt),
      .fault(fault_w[s]), .stalled(stalled_w[s]),
      .tgt(tgt_w[SIDE_W*s +: SIDE_W])
    );
  end

  pdn_bbm_writer #(.RELAY_DLY(RELAY_DLY)) u_wr (
    .clk(clk), .rst(rst),
    .start(seq_q == SEQ_WSTART),
    .tgt(tgt_w), .cmd(cont_cmd), .busy(busy_w)
  );

  pdn_bus_monitor u_bus (
    .clk(clk), .rst(rst),
    .health(health_q), .cmd(cont_cmd), .bus_pwr(bus_pwr)
  );

  assign stall = stalled_w;

  assert_skip_write_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_q == SEQ_READ || seq_q == SEQ_EVAL) |=> $stable(cont_cmd));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stall[0] && $past(stall[0])) |-> $stable(cont_cmd[2:0]));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (stall[1] && $past(stall[1])) |-> $stable(cont_cmd[5:3]));

  assert_central_joint_R9: assert property (@(posedge clk) disable iff (rst)
    !SPLIT_MODE |-> (stall[0] == stall[1]));
endmodule

// File: tb/pdn_reconfig_ctrl_tb_top.sv
module pdn_reconfig_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 6;
  localparam int SETTLE     = 3 * (DLY + 10);
  localparam int WDOG       = 100000;
  localparam int NVEC       = 10;

  // vector: {gen_l, gen_r, ru_l, ru_r, expected cont_cmd[5:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'b1111, 6'b011011}, {4'b1011, 6'b011101}, {4'b1111, 6'b011011},
    {4'b0111, 6'b011110}, {4'b0110, 6'b101110}, {4'b1101, 6'b110011},
    {4'b1001, 6'b110101}, {4'b0110, 6'b101110}, {4'b1110, 6'b101011},
    {4'b1111, 6'b011011}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gl = 1'b1, gr = 1'b1, rl = 1'b1, rr = 1'b1;
  logic [5:0] cmd_s, cmd_c;
  logic [3:0] bus_s, bus_c;
  logic [1:0] st_s, st_c;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdn_reconfig_ctrl #(.SPLIT_MODE(1'b1), .RELAY_DLY(DLY)) dut_i (
    .clk(clk), .rst(rst), .gen_l_ok(gl), .gen_r_ok(gr), .ru_l_ok(rl), .ru_r_ok(rr),
    .cont_cmd(cmd_s), .bus_pwr(bus_s), .stall(st_s));

  pdn_reconfig_ctrl #(.SPLIT_MODE(1'b0), .RELAY_DLY(DLY)) dut_c (
    .clk(clk), .rst(rst), .gen_l_ok(gl), .gen_r_ok(gr), .ru_l_ok(rl), .ru_r_ok(rr),
    .cont_cmd(cmd_c), .bus_pwr(bus_c), .stall(st_c));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_h(input logic [3:0] h);
    @(negedge clk);
    {gl, gr, rl, rr} = h;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {gl, gr, rl, rr} = 4'b1111;
    wait_n(2);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WDOG);
      finish_run();
    end
  end

  // R2 checked at the ports every cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_s[2:0] == 3'b111 || cmd_s[5:3] == 3'b111 ||
          cmd_c[2:0] == 3'b111 || cmd_c[5:3] == 3'b111) begin
        errors++;
        $display("FAIL R2 paralleling act=%0h/%0h exp=no triple closed", cmd_s, cmd_c);
      end
    end
  end

  initial begin
    logic [5:0] snap;
    int n;
    do_reset();
    // R1 reset state
    chk("R1 cmd", cmd_s, 6'b011011);
    chk("R1 stall", st_s, 2'b00);
    chk("R1 bus", bus_s, 4'b1111);

    // R3/R4/R11 table walk, both modes
    for (int v = 0; v < NVEC; v++) begin
      set_h(VEC[v][9:6]);
      wait_n(SETTLE);
      chk("R3 ac cmd split", cmd_s[2:0], VEC[v][2:0]);
      chk("R4 dc cmd split", cmd_s[5:3], VEC[v][5:3]);
      chk("R3 R4 cmd central", cmd_c, VEC[v][5:0]);
      chk("R11 bus powered", bus_s, 4'b1111);
    end

    // R6: no change while flags are steady
    snap = cmd_s;
    wait_n(60);
    chk("R6 stable", cmd_s, snap);

    // R5: openings first, closings RELAY_DLY cycles later
    set_h(4'b1011);
    n = 0;
    while (cmd_s[1] && n < 200) begin @(negedge clk); n++; end
    chk("R5 tie still open", cmd_s[2], 1'b0);
    n = 0;
    while (!cmd_s[2] && n < 200) begin @(negedge clk); n++; end
    chk("R5 gap", n, DLY);
    wait_n(SETTLE);

    // R7 / R9 / R10: generator double fault while reconfigured
    set_h(4'b0011);
    wait_n(SETTLE);
    chk("R7 stall split", st_s, 2'b01);
    chk("R7 ac held", cmd_s[2:0], 3'b101);
    chk("R10 ac unpowered", bus_s, 4'b1100);
    chk("R9 central stall", st_c, 2'b11);
    set_h(4'b0001);
    wait_n(SETTLE);
    chk("R9 split dc reacts", cmd_s[5:3], 3'b110);
    chk("R9 central dc frozen", cmd_c[5:3], 3'b011);
    set_h(4'b1111);
    wait_n(SETTLE);
    chk("R7 ac still held", cmd_s[2:0], 3'b101);
    chk("R7 stall sticky", st_s, 2'b01);
    chk("R10 tie path", bus_s, 4'b1111);

    // R8 / R9: rectifier double fault
    do_reset();
    set_h(4'b1110);
    wait_n(SETTLE);
    chk("R4 dc left only", cmd_s[5:3], 3'b101);
    set_h(4'b1100);
    wait_n(SETTLE);
    chk("R8 stall split", st_s, 2'b10);
    chk("R8 dc held", cmd_s[5:3], 3'b101);
    set_h(4'b1000);
    wait_n(SETTLE);
    chk("R9 split ac reacts", cmd_s[2:0], 3'b101);
    chk("R9 central ac frozen", cmd_c[2:0], 3'b011);
    chk("R9 central stall both", st_c, 2'b11);

    // R1: reset clears stall
    do_reset();
    chk("R1 stall cleared", st_s, 2'b00);
    chk("R1 cmd after stall", cmd_c, 6'b011011);
    finish_run();
  end
endmodule